// File: doc/BRIEF.md
# Deferred Nonvolatile Store Sequencer

This block sits behind a serial command decoder in a dual digitally controlled potentiometer and owns the data registers that stand in for nonvolatile storage. Each potentiometer has a small bank of these registers. The decoder raises a request strobe when it has fully received a command that changes stored data. There are three such commands: a host write of a data register, a copy of one pot's wiper counter into one of its data registers, and a global copy of every pot's wiper counter into the data register with the chosen index.

A request is only armed while chip select is low. Nothing is stored until chip select rises. At that rising edge an armed request turns into a store, as long as the active-low write-protect input is high. A busy timer then stands in for the cell programming time. Its length is a parameter, so a short value can be used in simulation while a real build uses milliseconds of cycles. During that time the write-in-progress flag is high, and the new value lands in the register on the cycle the flag falls.

While a store is in progress, new requests are not armed, so no second store can start behind it. An aborted frame drops whatever it had armed. The wip output stays readable throughout, which lets a decoder's status command be served at any time.

Top module: `nvs_store_seq`

## Requirements
- R1: After reset, wip is 0 and every data register of every pot reads 0.
- R2: A request with kind 2'b01 (host write) arms the store only while cs_n is low. On the first clock where cs_n is sampled high after having been low, the store commits, and wip reads 1 from the following cycle on. After the store, the register selected by req_pot and req_idx holds req_data, and no other register changes.
- R3: A request with kind 2'b10 (single wiper store) stores the slice of wcr_vals belonging to req_pot (bits pot*DW upward). That value is captured in the cycle the request is accepted; later changes of wcr_vals have no effect on it.
- R4: A request with kind 2'b11 (global store) writes each pot's own wcr_vals slice into that pot's register at req_idx, for every pot at once. req_pot is ignored.
- R5: wip stays high for exactly BUSY_CYCLES cycles. The target register keeps its old value while wip is high and shows the new value from the cycle wip falls.
- R6: If wp_n is low in the cycle where the chip-select rise is seen, the armed request is discarded, wip stays 0 and no register changes.
- R7: A pulse on frame_abort drops an armed request. Every chip-select rise also drops the armed request, whether it commits or not. A chip-select rise with nothing armed does nothing, and kind 2'b00 never arms.
- R8: Requests are not armed while wip is high or while cs_n is high.
- R9: If several requests arrive within one frame, only the last one accepted is stored.
- R10: rd_data always shows the register addressed by rd_pot and rd_idx, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low during a frame |
| wp_n | input | 1 | Write protect, low blocks stores |
| frame_abort | input | 1 | Pulse: the current frame was incomplete or invalid |
| req_valid | input | 1 | Pulse: a complete store command was decoded |
| req_kind | input | 2 | 00 none, 01 host write, 10 single wiper store, 11 global store |
| req_pot | input | PW | Target pot |
| req_idx | input | IW | Target data register index |
| req_data | input | DW | Host data for kind 01 |
| wcr_vals | input | NPOT*DW | Wiper counter values, pot p in bits p*DW upward |
| rd_pot | input | PW | Read address, pot |
| rd_idx | input | IW | Read address, register |
| rd_data | output | DW | Contents of the addressed register |
| wip | output | 1 | Write in progress |

## Verification
The assertions check the following on every cycle. wip may rise only right after a chip-select rise that found a request armed with write protect released. The timer count never goes past its reload value. The register bank stays unchanged on any cycle without a write strobe. No request is armed while busy, and a chip-select rise always leaves nothing armed. The exact busy length, which value ends up in which register (including the wiper value captured at accept time), last-request-wins and the abort and protect paths are shown by the bench scenarios. A behavioural model compares wip and the read port on every clock.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [1:0] {
    ST_NONE   = 2'b00,
    ST_HOST   = 2'b01,
    ST_WCR    = 2'b10,
    ST_GLOBAL = 2'b11
  } store_kind_e;

  // Which pots a store of this kind touches.
  function automatic logic pot_selected(store_kind_e k, int unsigned tgt, int unsigned p);
    case (k)
      ST_GLOBAL:      return 1'b1;
      ST_HOST,
      ST_WCR:         return (tgt == p);
      default:        return 1'b0;
    endcase
  endfunction

  function automatic logic is_store(store_kind_e k);
    return (k != ST_NONE);
  endfunction

  // Counter reload so that busy lasts exactly 'cycles' clocks.
  function automatic int unsigned busy_reload(int unsigned cycles);
    return (cycles > 0) ? cycles - 1 : 0;
  endfunction

endpackage

// File: rtl/nvs_arm.sv
module nvs_arm
  import nvs_pkg::*;
#(
  parameter int NPOT = 2,
  parameter int DW   = 6,
  parameter int IW   = 2,
  parameter int PW   = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 frame_abort,
  input  logic                 busy,
  input  logic                 req_valid,
  input  logic [1:0]           req_kind,
  input  logic [PW-1:0]        req_pot,
  input  logic [IW-1:0]        req_idx,
  input  logic [DW-1:0]        req_data,
  input  logic [NPOT*DW-1:0]   wcr_vals,
  output logic                 cs_rise,
  output logic                 armed,
  output store_kind_e          cap_kind,
  output logic [PW-1:0]        cap_pot,
  output logic [IW-1:0]        cap_idx,
  output logic [DW-1:0]        cap_data,
  output logic [NPOT*DW-1:0]   cap_wcr
);

  logic        cs_q;
  store_kind_e kind_in;
  logic        take;

  assign kind_in = store_kind_e'(req_kind);
  assign cs_rise = cs_n & ~cs_q;
  assign take    = req_valid & ~cs_n & ~busy & ~frame_abort & is_store(kind_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      armed    <= 1'b0;
      cap_kind <= ST_NONE;
      cap_pot  <= '0;
      cap_idx  <= '0;
      cap_data <= '0;
      cap_wcr  <= '0;
    end else begin
      cs_q <= cs_n;
      if (cs_rise || frame_abort) begin
        armed <= 1'b0;
      end else if (take) begin
        armed <= 1'b1;
      end
      if (take) begin
        cap_kind <= kind_in;
        cap_pot  <= req_pot;
        cap_idx  <= req_idx;
        cap_data <= req_data;
        cap_wcr  <= wcr_vals;
      end
    end
  end

  // R7: every chip-select rise leaves nothing armed
  p_rise_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !armed);

  // R8: arming never happens during a busy window
  p_no_arm_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> !$past(busy));

  // R8: arming never happens while deselected
  p_no_arm_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> !$past(cs_n));

endmodule

// File: rtl/nvs_timer.sv
module nvs_timer
  import nvs_pkg::*;
#(
  parameter int unsigned CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(busy_reload(CYCLES));

  logic [CW-1:0] cnt;

  assign done = busy & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= RELOAD;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R5: counter stays within the store window
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= RELOAD));

  // R5: every window begins at the full reload
  p_window_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cnt == RELOAD));

  // R8: a start never arrives during a window
  p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/nvs_bank.sv
module nvs_bank
  import nvs_pkg::*;
#(
  parameter int NPOT = 2,
  parameter int NREG = 4,
  parameter int DW   = 6,
  parameter int IW   = 2,
  parameter int PW   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  store_kind_e        kind,
  input  logic [PW-1:0]      pot,
  input  logic [IW-1:0]      idx,
  input  logic [DW-1:0]      data,
  input  logic [NPOT*DW-1:0] wcr,
  input  logic [PW-1:0]      rd_pot,
  input  logic [IW-1:0]      rd_idx,
  output logic [DW-1:0]      rd_data
);

  logic [NPOT-1:0][NREG-1:0][DW-1:0] mem;
  logic [NPOT-1:0]                   pot_we;
  logic [NPOT-1:0][DW-1:0]           new_word;

  function automatic logic [DW-1:0] store_word(store_kind_e k, logic [DW-1:0] host,
                                              logic [DW-1:0] wiper);
    return (k == ST_HOST) ? host : wiper;
  endfunction

  for (genvar gp = 0; gp < NPOT; gp++) begin : g_pot
    assign pot_we[gp]   = we & pot_selected(kind, int'(pot), gp);
    assign new_word[gp] = store_word(kind, data, wcr[gp*DW +: DW]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
    end else begin
      for (int p = 0; p < NPOT; p++) begin
        for (int r = 0; r < NREG; r++) begin
          if (pot_we[p] && (int'(idx) == r)) mem[p][r] <= new_word[p];
        end
      end
    end
  end

  assign rd_data = mem[rd_pot][rd_idx];

  // R6: storage is frozen on every cycle without a write strobe
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem));

endmodule

// File: rtl/nvs_store_seq.sv
module nvs_store_seq
  import nvs_pkg::*;
#(
  parameter int          NPOT        = 2,
  parameter int          NREG        = 4,
  parameter int          DW          = 6,
  parameter int unsigned BUSY_CYCLES = 250000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 wp_n,
  input  logic                 frame_abort,
  input  logic                 req_valid,
  input  logic [1:0]           req_kind,
  input  logic [((NPOT > 1) ? $clog2(NPOT) : 1)-1:0] req_pot,
  input  logic [((NREG > 1) ? $clog2(NREG) : 1)-1:0] req_idx,
  input  logic [DW-1:0]        req_data,
  input  logic [NPOT*DW-1:0]   wcr_vals,
  input  logic [((NPOT > 1) ? $clog2(NPOT) : 1)-1:0] rd_pot,
  input  logic [((NREG > 1) ? $clog2(NREG) : 1)-1:0] rd_idx,
  output logic [DW-1:0]        rd_data,
  output logic                 wip
);

  localparam int PW = (NPOT > 1) ? $clog2(NPOT) : 1;
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic               cs_rise;
  logic               armed;
  store_kind_e        cap_kind;
  logic [PW-1:0]      cap_pot;
  logic [IW-1:0]      cap_idx;
  logic [DW-1:0]      cap_data;
  logic [NPOT*DW-1:0] cap_wcr;
  logic               commit_fire;
  logic               store_done;
  logic               busy;

  nvs_arm #(.NPOT(NPOT), .DW(DW), .IW(IW), .PW(PW)) u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .frame_abort(frame_abort),
    .busy       (busy),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_pot    (req_pot),
    .req_idx    (req_idx),
    .req_data   (req_data),
    .wcr_vals   (wcr_vals),
    .cs_rise    (cs_rise),
    .armed      (armed),
    .cap_kind   (cap_kind),
    .cap_pot    (cap_pot),
    .cap_idx    (cap_idx),
    .cap_data   (cap_data),
    .cap_wcr    (cap_wcr)
  );

  assign commit_fire = cs_rise & armed & wp_n;

  nvs_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(commit_fire),
    .busy (busy),
    .done (store_done)
  );

  nvs_bank #(.NPOT(NPOT), .NREG(NREG), .DW(DW), .IW(IW), .PW(PW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (store_done),
    .kind   (cap_kind),
    .pot    (cap_pot),
    .idx    (cap_idx),
    .data   (cap_data),
    .wcr    (cap_wcr),
    .rd_pot (rd_pot),
    .rd_idx (rd_idx),
    .rd_data(rd_data)
  );

  assign wip = busy;

  // R2: a store window opens only right after a chip-select rise with a request armed
  p_wip_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> ($past(cs_rise) && $past(armed)));

  // R6: a store window never opens with write protect asserted
  p_wp_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wp_n));

  // R5: the window closes only through the bank write
  p_write_on_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> $past(store_done));

endmodule

// File: tb/tb_nvs_store_seq.sv
module tb_nvs_store_seq;

  localparam int BUSY = 12;
  localparam int DW   = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        wp_n = 1'b1;
  logic        frame_abort = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic        req_pot = 1'b0;
  logic [1:0]  req_idx = 2'b00;
  logic [5:0]  req_data = '0;
  logic [11:0] wcr_vals = '0;
  logic        rd_pot = 1'b0;
  logic [1:0]  rd_idx = 2'b00;
  logic [5:0]  rd_data;
  logic        wip;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 0;
  bit    mon_on = 0;
  string cur_tag = "R1";
  bit    swap_wcr = 0;
  logic [11:0] wcr_alt = '0;

  nvs_store_seq #(.NPOT(2), .NREG(4), .DW(DW), .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .frame_abort(frame_abort),
    .req_valid(req_valid), .req_kind(req_kind), .req_pot(req_pot), .req_idx(req_idx),
    .req_data(req_data), .wcr_vals(wcr_vals), .rd_pot(rd_pot), .rd_idx(rd_idx),
    .rd_data(rd_data), .wip(wip)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Behavioural reference model
  int m_reg[2][4];
  int m_left;
  bit m_pend;
  int m_kind, m_pot, m_idx, m_data, m_w0, m_w1;
  bit m_cs_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_reg[p, r]) m_reg[p][r] = 0;
      m_left = 0; m_pend = 0; m_cs_prev = 1;
      m_kind = 0; m_pot = 0; m_idx = 0; m_data = 0; m_w0 = 0; m_w1 = 0;
    end else begin
      automatic bit old_busy = (m_left > 0);
      automatic bit rise = cs_n && !m_cs_prev;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          for (int p = 0; p < 2; p++) begin
            if (m_kind == 3 || m_pot == p)
              m_reg[p][m_idx] = (m_kind == 1) ? m_data : ((p == 0) ? m_w0 : m_w1);
          end
        end
      end
      if (rise) begin
        if (m_pend && wp_n && !old_busy) m_left = BUSY;
        m_pend = 0;
      end else if (frame_abort) begin
        m_pend = 0;
      end else if (req_valid && !cs_n && !old_busy && req_kind != 2'b00) begin
        m_pend = 1;
        m_kind = int'(req_kind); m_pot = int'(req_pot); m_idx = int'(req_idx);
        m_data = int'(req_data);
        m_w0 = int'(wcr_vals[5:0]); m_w1 = int'(wcr_vals[11:6]);
      end
      m_cs_prev = cs_n;
    end
  end

  // Per-clock comparison against the model
  always begin
    @(posedge clk);
    #5;
    if (mon_on) begin
      chk({cur_tag, " wip per-cycle"}, int'(wip), (m_left > 0) ? 1 : 0);
      chk({cur_tag, " rd_data per-cycle"}, int'(rd_data), m_reg[rd_pot][rd_idx]);
    end
  end

  task automatic rdchk(string tag, int p, int i, int exp);
    rd_pot = p[0];
    rd_idx = i[1:0];
    #1;
    chk(tag, int'(rd_data), exp);
  endtask

  // One frame with a single request; returns at the first negedge after commit.
  task automatic frame(logic [1:0] k, int pot, int idx, int dat, bit abort, bit wp);
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_pot = pot[0]; req_idx = idx[1:0]; req_data = dat[5:0];
    @(negedge clk) req_valid = 1'b0;
    if (swap_wcr) wcr_vals = wcr_alt;
    if (abort) begin
      frame_abort = 1'b1;
      @(negedge clk) frame_abort = 1'b0;
    end
    wp_n = wp;
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk) wp_n = 1'b1;
  endtask

  // Counts wip-high cycles starting at the current negedge.
  task automatic win(string tag, int exp);
    int c = int'(wip);
    repeat (BUSY + 2) begin
      @(negedge clk);
      c += int'(wip);
    end
    chk(tag, c, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1;

    // R1: reset state
    cur_tag = "R1";
    chk("R1 wip after reset", int'(wip), 0);
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 4; i++) rdchk("R1 register after reset", p, i, 0);

    // R2 / R5: host write, busy window, old value during, new value after
    cur_tag = "R2";
    frame(2'b01, 1, 2, 42, 0, 1);
    chk("R2 wip one cycle after cs rise", int'(wip), 1);
    rdchk("R5 old value while busy", 1, 2, 0);
    win("R5 busy window length", BUSY);
    rdchk("R2 host data stored", 1, 2, 42);
    rdchk("R2 other pot untouched", 0, 2, 0);

    // R3: single wiper store captures value at accept time
    cur_tag = "R3";
    wcr_vals = {6'h33, 6'h11};
    wcr_alt  = {6'h33, 6'h05};
    swap_wcr = 1;
    frame(2'b10, 0, 1, 0, 0, 1);
    swap_wcr = 0;
    win("R3 busy window length", BUSY);
    rdchk("R3 captured wiper value stored", 0, 1, 17);
    rdchk("R3 other pot untouched", 1, 1, 0);

    // R4: global store writes every pot
    cur_tag = "R4";
    wcr_vals = {6'h3F, 6'h07};
    frame(2'b11, 0, 3, 0, 0, 1);
    win("R4 busy window length", BUSY);
    rdchk("R4 pot0 gets its wiper", 0, 3, 7);
    rdchk("R4 pot1 gets its wiper", 1, 3, 63);
    cur_tag = "R10";
    rdchk("R10 read port pot1 idx2", 1, 2, 42);
    rdchk("R10 read port pot0 idx0", 0, 0, 0);

    // R6: write protect at commit discards the request
    cur_tag = "R6";
    frame(2'b01, 0, 0, 21, 0, 0);
    win("R6 no busy under write protect", 0);
    rdchk("R6 register unchanged", 0, 0, 0);

    // R7: cs pulse with nothing armed, then aborted frame
    cur_tag = "R7";
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    win("R7 empty frame does nothing", 0);
    frame(2'b01, 1, 3, 43, 1, 1);
    win("R7 aborted frame does nothing", 0);
    rdchk("R7 register kept after abort", 1, 3, 63);
    frame(2'b00, 1, 3, 9, 0, 1);
    win("R7 kind none never arms", 0);

    // R9: last request in a frame wins
    cur_tag = "R9";
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b01; req_pot = 1'b0; req_idx = 2'd2; req_data = 6'd10;
    @(negedge clk);
    req_idx = 2'd3; req_data = 6'd11;
    @(negedge clk) req_valid = 1'b0;
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    win("R9 single store window", BUSY);
    rdchk("R9 last request stored", 0, 3, 11);
    rdchk("R9 earlier request dropped", 0, 2, 0);

    // R8: request during busy is ignored
    cur_tag = "R8";
    frame(2'b01, 0, 0, 1, 0, 1);
    frame(2'b01, 1, 0, 62, 0, 1);
    repeat (BUSY + 4) @(negedge clk);
    chk("R8 wip clear after window", int'(wip), 0);
    rdchk("R8 first store done", 0, 0, 1);
    rdchk("R8 store during busy ignored", 1, 0, 0);

    // R8: request with cs_n high is ignored
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b01; req_pot = 1'b0; req_idx = 2'd1; req_data = 6'd9;
    @(negedge clk) req_valid = 1'b0;
    frame(2'b00, 0, 1, 0, 0, 1);
    win("R8 deselected request never stored", 0);
    rdchk("R8 register kept", 0, 1, 17);

    repeat (2) @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

endmodule